// File: doc/BRIEF.md
# Segmented Carry-Skip Adder

This block is a purely combinational binary adder for a 32-bit datapath. It adds two unsigned operands and a single carry input, returning the low word of the result together with the carry that leaves the most significant bit. It can be used wherever a single-cycle add must fit a timing budget that a plain ripple chain misses. The adder is also cheaper in area than a full lookahead tree.

Internally the word is cut into equal segments, eight bits wide by default. Every bit first forms its propagate term from the two operand bits alone, so this setup work does not wait for any carry. A simple carry cell then moves the carry from bit to bit inside a segment. At the top of each segment a two-way selector hands the next segment either the carry that rippled out of this segment or, when every bit of the segment propagates, the carry that entered it. A carry born in the lowest bit therefore ripples through the first segment, crosses the middle segments through their selectors and ripples again only in the last segment.

Top module: `csk_adder`

## Requirements
- R1: `sum_o` equals the low 32 bits of `a_i + b_i + cin_i`, taken as unsigned integers.
- R2: `cout_o` equals bit 32 of the 33-bit unsigned sum `a_i + b_i + cin_i`, and it is driven by the skip selector of the most significant segment.
- R3: Each bit's propagate term is `a XOR b`. Its sum bit is that term XOR the carry entering the bit, so operands with no bit position where both are 1 add without any carry (for example 0x0F0F0F0F + 0xF0F0F0F0 = 0xFFFFFFFF).
- R4: The carry out of a bit is (propagate AND carry-in) OR (a AND b). A bit where both operands are 1 always emits a carry, and a bit where both are 0 never does.
- R5: A segment's group propagate is the AND of its per-bit propagate terms. When it is true, the carry the segment passes upward equals the carry that entered it.
- R6: When a segment's group propagate is false, the carry it passes upward is the carry rippled out of its top bit.
- R7: A carry generated at bit 0 reaches every higher bit whose lower neighbours all propagate, including the top bit and `cout_o` (0xFFFFFFFF + 0x00000001 gives sum 0 and carry 1).
- R8: The width is a parameter that must be an integer multiple of the segment width; the segment count is derived from the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Low word of the result |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
The bench builds the adder with its default values: 32 bits in four segments of eight. With this shape there is a first segment, two middle segments that can only be crossed by skipping, and a last segment. So the operand patterns can steer a bit-0 carry across zero, one or two bypassed segments, and can force a skip to be refused by putting one killing bit inside an otherwise propagating segment. Random operands cover the mixed cases between these corners.

// File: rtl/csk_pkg.sv
package csk_pkg;

  // carry leaving one bit position: generate, or propagate an incoming carry
  function automatic logic carry_step(input logic prop, input logic gen, input logic c_in);
    return gen | (prop & c_in);
  endfunction

  // selector at a segment boundary
  function automatic logic skip_pick(input logic grp_prop, input logic bypass, input logic rippled);
    return grp_prop ? bypass : rippled;
  endfunction

endpackage

// File: rtl/csk_bit_cell.sv
module csk_bit_cell
  import csk_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic c_o,
  output logic s_o
);

  logic gen;

  // setup stage, independent of the carry
  assign p_o = a_i ^ b_i;
  assign gen = a_i & b_i;

  assign c_o = carry_step(p_o, gen, c_i);
  assign s_o = p_o ^ c_i;

  always_comb begin
    // R4
    gen_forces_carry_chk: assert (!(a_i && b_i) || c_o)
      else $error("bit cell: both operands set but no carry");
    // R4
    kill_blocks_carry_chk: assert ((a_i || b_i) || !c_o)
      else $error("bit cell: both operands clear but carry emitted");
    // R3
    bit_add_chk: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {1'b0, c_i}))
      else $error("bit cell: sum/carry pair differs from full add");
  end

endmodule

// File: rtl/csk_skip_mux.sv
module csk_skip_mux
  import csk_pkg::*;
(
  input  logic sel_i,
  input  logic bypass_i,
  input  logic ripple_i,
  output logic out_o
);

  assign out_o = skip_pick(sel_i, bypass_i, ripple_i);

endmodule

// File: rtl/csk_segment.sv
module csk_segment #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] a_i,
  input  logic [SEG_W-1:0] b_i,
  input  logic             cin_i,
  output logic [SEG_W-1:0] sum_o,
  output logic             grp_prop_o,
  output logic             ripple_o,
  output logic             cout_o
);

  logic [SEG_W:0]   chain;
  logic [SEG_W-1:0] prop;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < SEG_W; i++) begin : g_bit
    csk_bit_cell u_cell (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (chain[i]),
      .p_o (prop[i]),
      .c_o (chain[i+1]),
      .s_o (sum_o[i])
    );
  end

  assign ripple_o   = chain[SEG_W];
  assign grp_prop_o = &prop;

  csk_skip_mux u_skip (
    .sel_i    (grp_prop_o),
    .bypass_i (cin_i),
    .ripple_i (ripple_o),
    .out_o    (cout_o)
  );

  always_comb begin
    // R5
    skip_matches_ripple_chk: assert (!grp_prop_o || (ripple_o == cin_i))
      else $error("segment: full propagate but ripple differs from carry-in");
    // R6
    no_skip_uses_ripple_chk: assert (grp_prop_o || (cout_o == ripple_o))
      else $error("segment: skip refused but output differs from ripple");
    // R5
    skip_out_chk: assert (!grp_prop_o || (cout_o == cin_i))
      else $error("segment: skip taken but output differs from carry-in");
    // R3
    seg_add_chk: assert ({ripple_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{SEG_W{1'b0}}, cin_i}))
      else $error("segment: local sum differs from segment add");
  end

endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
  parameter int WIDTH = 32,
  parameter int SEG_W = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int NSEG = WIDTH / SEG_W;

  // R8: width must split evenly into segments
  if ((WIDTH % SEG_W) != 0 || SEG_W < 1) begin : g_bad_shape
    $error("csk_adder: WIDTH must be a positive multiple of SEG_W");
  end

  logic [NSEG:0]   seg_c;
  logic [NSEG-1:0] seg_skip;
  logic [NSEG-1:0] seg_ripple;

  assign seg_c[0] = cin_i;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    csk_segment #(.SEG_W(SEG_W)) u_seg (
      .a_i        (a_i[s*SEG_W +: SEG_W]),
      .b_i        (b_i[s*SEG_W +: SEG_W]),
      .cin_i      (seg_c[s]),
      .sum_o      (sum_o[s*SEG_W +: SEG_W]),
      .grp_prop_o (seg_skip[s]),
      .ripple_o   (seg_ripple[s]),
      .cout_o     (seg_c[s+1])
    );
  end

  assign cout_o = seg_c[NSEG];

  function automatic logic [WIDTH:0] ref_add(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] y,
                                             input logic             c);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, c};
  endfunction

  always_comb begin
    // R1
    word_sum_chk: assert (sum_o == ref_add(a_i, b_i, cin_i)[WIDTH-1:0])
      else $error("adder: sum word mismatch");
    // R2
    carry_out_chk: assert (cout_o == ref_add(a_i, b_i, cin_i)[WIDTH])
      else $error("adder: carry-out mismatch");
    // R7
    all_prop_chk: assert (!(&seg_skip) || (cout_o == cin_i))
      else $error("adder: all segments propagate but carry-out differs from carry-in");
  end

endmodule

// File: tb/csk_adder_test.sv
module csk_adder_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int           n_checks = 0;
  int           n_errors = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  csk_adder uut (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  // independent reference: bit-serial full adder
  function automatic logic [W:0] expect_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    logic [W:0] r;
    logic cc;
    cc = c;
    for (int i = 0; i < W; i++) begin
      r[i] = x[i] ^ y[i] ^ cc;
      cc = (x[i] & y[i]) | (x[i] & cc) | (y[i] & cc);
    end
    r[W] = cc;
    return r;
  endfunction

  task automatic apply_check(input string req, input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    logic [W:0] e;
    @(negedge clk);
    a = x; b = y; cin = c;
    @(posedge clk);
    #1;
    e = expect_add(x, y, c);
    n_checks++;
    if ({cout, sum} !== e) begin
      n_errors++;
      $display("FAIL %s: a=%h b=%h cin=%b actual=%b_%h expected=%b_%h",
               req, x, y, c, cout, sum, e[W], e[W-1:0]);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    // R1 idle inputs give zero
    apply_check("R1 zero", 32'h0, 32'h0, 1'b0);
    // R3 pure propagate, no carries anywhere
    apply_check("R3 propagate only", 32'h0F0F0F0F, 32'hF0F0F0F0, 1'b0);
    // R3 all propagate, carry-in 1 wraps to zero
    apply_check("R3 all propagate cin", 32'hFFFFFFFF, 32'h0, 1'b1);
    // R4 generate at top bit
    apply_check("R4 top generate", 32'h80000000, 32'h80000000, 1'b0);
    // R4 kill everywhere, carry-in only reaches bit 0
    apply_check("R4 kill", 32'h0, 32'h0, 1'b1);
    // R5 carry from segment 0 skips segment 1
    apply_check("R5 skip one", 32'h0000FF80, 32'h00000080, 1'b0);
    // R5 carry skips segments 1 and 2
    apply_check("R5 skip two", 32'h00FFFF80, 32'h00000080, 1'b0);
    // R6 one killing bit in segment 1 stops skip
    apply_check("R6 no skip", 32'h0000FE80, 32'h00000080, 1'b0);
    // R6 generate inside segment 2 ripples out
    apply_check("R6 ripple out", 32'h00800000, 32'h00800000, 1'b0);
    // R7 longest path
    apply_check("R7 bit0 to top", 32'hFFFFFFFF, 32'h00000001, 1'b0);
    apply_check("R7 bit0 cin", 32'hFFFFFFFE, 32'h00000001, 1'b1);
    // R2 carry-out with carry-in
    apply_check("R2 cout", 32'h80000000, 32'h80000000, 1'b1);
    apply_check("R2 no cout", 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1);
    // R8 default shape: each segment boundary crossed by a carry
    for (int s = 1; s < 4; s++)
      apply_check("R8 boundary", 32'h1 << (s*8 - 1), 32'h1 << (s*8 - 1), 1'b0);
    // R1 R2 random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] x, y;
      x = $urandom();
      y = $urandom();
      if (k % 4 == 1) y = ~x;
      if (k % 4 == 2) y = ~x ^ (32'h1 << (k % 32));
      apply_check("R1 random", x, y, 1'($urandom() & 1));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule